// File: doc/BRIEF.md
# Auxiliary Register Address Unit

This block generates indirect data-memory addresses from a small file of auxiliary registers. A pointer register selects one register of the file as the current one. Its contents drive the address output. In the same clock cycle the block can step that register by one or by a separate index register, in either direction. Address arithmetic therefore never needs the main arithmetic unit, and a loop can walk a table while other work proceeds.

Any register can be loaded directly through a write port, and any register can be read back through a separate read-select port. The pointer and the index register each have their own load port. A pointer load changes the current register from the next cycle onward. The address output always shows the register value before any modification is applied, which gives post-modify semantics.

Top module: `aux_addr_unit`

## Requirements
- R1: After reset every auxiliary register, the pointer and the index register are zero, so `addr_out` and `rd_data` read 0.
- R2: `addr_out` combinationally shows the register selected by the pointer, with its value before any modification that the current cycle applies.
- R3: With `mod_op` = 3'b001, the current register is incremented by one at the clock edge.
- R4: With `mod_op` = 3'b010, the current register is decremented by one at the clock edge.
- R5: With `mod_op` = 3'b011, the index register is added to the current register. `idx_ld` loads the index from `idx_val` at the clock edge, and the new index is used from the next cycle.
- R6: With `mod_op` = 3'b100, the index register is subtracted from the current register.
- R7: The codes 3'b000, 3'b101, 3'b110 and 3'b111 leave the current register unchanged.
- R8: All modification arithmetic wraps modulo 2^16. 16'hFFFF + 1 gives 0, and 0 - 1 gives 16'hFFFF.
- R9: With `wr_en` high, register `wr_sel` takes `wr_data` at the clock edge. `rd_data` combinationally shows the register named by `rd_sel`.
- R10: When a write and a modification target the same register in one cycle, the written value is stored.
- R11: `ptr_ld` loads the pointer from `ptr_val` at the clock edge. In that cycle the address and the modification still use the old pointer.
- R12: A modification changes only the current register. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Explicit register write enable |
| wr_sel | input | 3 | Register number to write |
| wr_data | input | 16 | Value to write |
| ptr_ld | input | 1 | Pointer load enable |
| ptr_val | input | 3 | New pointer value |
| idx_ld | input | 1 | Index register load enable |
| idx_val | input | 16 | New index value |
| mod_op | input | 3 | Modification code for the current register |
| rd_sel | input | 3 | Register number for readback |
| addr_out | output | 16 | Current register value used as the address |
| rd_data | output | 16 | Readback of the register named by rd_sel |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any stimulus. They also assume that the select inputs always carry known values, because an unknown pointer or write select would make the next-cycle register comparisons meaningless. The bench drives every input from zero during reset and changes inputs only on the falling edge. It sweeps all pointer values against all eight modification codes, then runs a random sequence in which every field is drawn from its full legal range. As a result, no select input ever carries an unknown value.

// File: rtl/aux_addr_unit.sv
module aux_addr_unit #(
  parameter int DW   = 16,
  parameter int NREG = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(NREG)-1:0] wr_sel,
  input  logic [DW-1:0]           wr_data,
  input  logic                    ptr_ld,
  input  logic [$clog2(NREG)-1:0] ptr_val,
  input  logic                    idx_ld,
  input  logic [DW-1:0]           idx_val,
  input  logic [2:0]              mod_op,
  input  logic [$clog2(NREG)-1:0] rd_sel,
  output logic [DW-1:0]           addr_out,
  output logic [DW-1:0]           rd_data
);
  localparam int PW = $clog2(NREG);
  localparam logic [2:0] OP_INC  = 3'b001;
  localparam logic [2:0] OP_DEC  = 3'b010;
  localparam logic [2:0] OP_ADDX = 3'b011;
  localparam logic [2:0] OP_SUBX = 3'b100;

  logic [DW-1:0] arf [NREG];
  logic [PW-1:0] ptr_q;
  logic [DW-1:0] idx_q;
  logic [DW-1:0] nxt;

  assign addr_out = arf[ptr_q];
  assign rd_data  = arf[rd_sel];

  always_comb begin
    case (mod_op)
      OP_INC:  nxt = addr_out + DW'(1);
      OP_DEC:  nxt = addr_out - DW'(1);
      OP_ADDX: nxt = addr_out + idx_q;
      OP_SUBX: nxt = addr_out - idx_q;
      default: nxt = addr_out;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) arf[i] <= '0;
      ptr_q <= '0;
      idx_q <= '0;
    end else begin
      arf[ptr_q] <= nxt;
      if (wr_en) arf[wr_sel] <= wr_data;
      if (ptr_ld) ptr_q <= ptr_val;
      if (idx_ld) idx_q <= idx_val;
    end
  end

  // R3
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && mod_op == OP_INC) |=> arf[$past(ptr_q)] == DW'($past(addr_out) + 1'b1));

  // R4
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && mod_op == OP_DEC) |=> arf[$past(ptr_q)] == DW'($past(addr_out) - 1'b1));

  // R5
  add_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && mod_op == OP_ADDX) |=> arf[$past(ptr_q)] == DW'($past(addr_out) + $past(idx_q)));

  // R6
  sub_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && mod_op == OP_SUBX) |=> arf[$past(ptr_q)] == DW'($past(addr_out) - $past(idx_q)));

  // R7
  hold_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && (mod_op == 3'b000 || mod_op > OP_SUBX)) |=> arf[$past(ptr_q)] == $past(addr_out));

  // R10
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> arf[$past(wr_sel)] == $past(wr_data));

  // R11
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_ld |=> ptr_q == $past(ptr_val));

  // R12
  other_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rd_sel != ptr_q) |=> arf[$past(rd_sel)] == $past(rd_data));
endmodule

// File: tb/test_aux_addr_unit.sv
`timescale 1ns/1ps
module test_aux_addr_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, ptr_ld = 1'b0, idx_ld = 1'b0;
  logic [2:0] wr_sel = '0, ptr_val = '0, mod_op = '0, rd_sel = '0;
  logic [15:0] wr_data = '0, idx_val = '0;
  logic [15:0] addr_out, rd_data;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] m_reg [8];
  logic [2:0]  m_ptr;
  logic [15:0] m_idx;

  always #2 clk = ~clk;

  aux_addr_unit i_aux_addr_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ptr_ld(ptr_ld), .ptr_val(ptr_val), .idx_ld(idx_ld), .idx_val(idx_val),
    .mod_op(mod_op), .rd_sel(rd_sel), .addr_out(addr_out), .rd_data(rd_data));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one cycle, check combinational outputs before the edge, then update the model
  task automatic cyc(string req, bit we, logic [2:0] ws, logic [15:0] wd, bit pl,
                     logic [2:0] pv, bit il, logic [15:0] iv, logic [2:0] op, logic [2:0] rs);
    logic [15:0] cur;
    @(negedge clk);
    wr_en = we; wr_sel = ws; wr_data = wd; ptr_ld = pl; ptr_val = pv;
    idx_ld = il; idx_val = iv; mod_op = op; rd_sel = rs;
    #1;
    chk({req, " addr"}, addr_out, m_reg[m_ptr]);
    chk({req, " read"}, rd_data, m_reg[rs]);
    @(posedge clk);
    cur = m_reg[m_ptr];
    case (op)
      3'b001: m_reg[m_ptr] = cur + 16'd1;
      3'b010: m_reg[m_ptr] = cur - 16'd1;
      3'b011: m_reg[m_ptr] = cur + m_idx;
      3'b100: m_reg[m_ptr] = cur - m_idx;
      default: ;
    endcase
    if (we) m_reg[ws] = wd;
    if (pl) m_ptr = pv;
    if (il) m_idx = iv;
  endtask

  task automatic readall(string req);
    for (int r = 0; r < 8; r++) cyc(req, 0, 0, 0, 0, 0, 0, 0, 3'b000, 3'(r));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 8; r++) m_reg[r] = '0;
    m_ptr = '0; m_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    readall("R1");
    // R9 load distinct values into every register
    for (int r = 0; r < 8; r++) cyc("R9", 1, 3'(r), 16'h1000 * 16'(r) + 16'h0100, 0, 0, 0, 0, 0, 3'(r));
    readall("R9");
    // R5 index load, then sweep all pointers against all codes
    cyc("R5", 0, 0, 0, 0, 0, 1, 16'h0025, 0, 0);
    for (int p = 0; p < 8; p++)
      for (int op = 0; op < 8; op++) begin
        cyc("R11", 0, 0, 0, 1, 3'(p), 0, 0, 0, 0);
        cyc("R2", 0, 0, 0, 0, 0, 0, 0, 3'(op), 3'(p));
        cyc(op == 1 ? "R3" : op == 2 ? "R4" : op == 3 ? "R5" : op == 4 ? "R6" : "R7",
            0, 0, 0, 0, 0, 0, 0, 0, 3'(p));
        readall("R12");
      end
    // R8 wrap both ways
    cyc("R8", 1, 3'd2, 16'hFFFF, 1, 3'd2, 0, 0, 0, 0);
    cyc("R8", 0, 0, 0, 0, 0, 0, 0, 3'b001, 3'd2);
    cyc("R8", 0, 0, 0, 0, 0, 0, 0, 3'b010, 3'd2);
    cyc("R8", 0, 0, 0, 0, 0, 0, 0, 0, 3'd2);
    cyc("R8", 0, 0, 0, 0, 0, 1, 16'h8001, 3'b100, 3'd2);
    cyc("R8", 0, 0, 0, 0, 0, 0, 0, 3'b011, 3'd2);
    cyc("R8", 0, 0, 0, 0, 0, 0, 0, 0, 3'd2);
    // R10 write and modify collide on the current register
    cyc("R10", 1, 3'd2, 16'h5A5A, 0, 0, 0, 0, 3'b011, 3'd2);
    cyc("R10", 0, 0, 0, 0, 0, 0, 0, 0, 3'd2);
    // R11 pointer load in the same cycle as a modify: old register moves
    cyc("R11", 0, 0, 0, 1, 3'd6, 0, 0, 3'b001, 3'd2);
    cyc("R11", 0, 0, 0, 0, 0, 0, 0, 0, 3'd2);
    cyc("R11", 0, 0, 0, 0, 0, 0, 0, 0, 3'd6);
    // random sequence
    for (int k = 0; k < 3000; k++)
      cyc("R2", 1'($urandom % 4 == 0), 3'($urandom), 16'($urandom), 1'($urandom % 3 == 0),
          3'($urandom), 1'($urandom % 5 == 0), 16'($urandom), 3'($urandom), 3'($urandom));
    readall("R12");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule